// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped primary cache and holds blocks that the primary has recently thrown out. Each entry keeps the full block address (primary tag and primary index together, since the buffer has no index of its own) and a payload of parameterized width. When the primary misses, it presents the requested block address on the lookup port. In the same cycle it presents the block it is about to displace, if that line held valid data, on the eviction port.

On a buffer hit, the stored payload is returned combinationally for the primary to take in. The displaced primary block is then written into the very slot that the hit block leaves free, so no memory fetch is needed. The LRU entry is not disturbed. On a buffer miss, the primary fetches from memory as usual and the displaced block is written into the buffer. It goes into a free slot if one exists, and otherwise over the least recently used entry. Every block written into the buffer becomes most recently used. A hit with no displaced block frees the slot.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty, so the first lookup of any address reports a miss.
- R2: `lk_hit` is high only in a cycle with `lk_valid` high and a stored valid entry whose full block address equals `lk_addr`; `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low; with `lk_valid` low both are low.
- R3: During a hit, `sw_data` carries the payload stored with the matching entry, in the same cycle.
- R4: On a hit with `ev_valid` high, the evicted block (address and payload) is stored in the slot the hit entry came from; every other entry keeps its contents.
- R5: On a hit with `ev_valid` low, the hit entry is removed and a later lookup of its address misses.
- R6: A block written with `ev_valid` while no hit occurs goes into an empty slot whenever one exists, so up to ENTRIES distinct blocks are all retained.
- R7: When all entries are valid and a non-hit write arrives, the least recently written entry is the one replaced.
- R8: A block written into the buffer, whether by insertion or by swap, becomes most recently used; a hit without a write leaves the relative order of the remaining entries unchanged.
- R9: With a one-line primary and the alternating trace A B A B ..., only the first two accesses go to memory; every later access hits in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request (primary missed) |
| lk_addr | input | ADDR_W | Full block address being looked up |
| ev_valid | input | 1 | Primary is displacing a valid block this cycle |
| ev_addr | input | ADDR_W | Full block address of the displaced block |
| ev_data | input | DATA_W | Payload of the displaced block |
| lk_hit | output | 1 | Lookup found the block in the buffer |
| lk_miss | output | 1 | Lookup did not find the block; memory fetch needed |
| sw_data | output | DATA_W | Payload of the hit entry, moved into the primary |

## Verification
The bench targets the replacement order after a swap. A design that refreshed every entry's age on a hit, or that aged the swapped-in block as old, would evict the wrong block on the next full insertion. It also checks that a swap reuses the hit slot. A design that sent the displaced block to the LRU slot would lose a still-live block, and a later lookup would miss where a hit is expected. Fill-before-replace and the freeing of a slot on a hit without a displaced block are exercised directly. A design that overwrote valid entries while others were empty, or kept a stale copy after the block moved, would return wrong hits. A random stream over a small address pool, checked against a timestamp model, mixes these cases. Finally, the alternating two-block conflict trace confirms that memory is touched only twice.

// File: rtl/vb_pkg.sv
package vb_pkg;

  localparam int MAX_ENTRIES = 16;

  // index of the lowest set bit, 0 when none
  function automatic int lowest_set(input logic [MAX_ENTRIES-1:0] v);
    int r;
    r = 0;
    for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // rank after a touch: entries more recent than the touched one age by one
  function automatic int next_rank(input int cur, input int touched_rank,
                                   input bit is_touched);
    if (is_touched) return 0;
    if (cur < touched_rank) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              addr,
  output logic [ENTRIES-1:0]             match,
  output logic                           any,
  output logic [IW-1:0]                  idx
);
  import vb_pkg::*;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == addr);
  end

  assign any = |match;

  always_comb begin
    logic [MAX_ENTRIES-1:0] wide;
    wide = '0;
    wide[ENTRIES-1:0] = match;
    idx = IW'(lowest_set(wide));
  end

  // R2: distinct stored addresses, so at most one comparator fires
  always_comb begin
    a_r2_single_match: assert ($onehot0(match));
  end

endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
  parameter int ENTRIES = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  import vb_pkg::*;

  logic [ENTRIES-1:0][IW-1:0] rank_q;
  logic [ENTRIES-1:0]         is_oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++)
        rank_q[i] <= IW'(next_rank(int'(rank_q[i]), int'(rank_q[touch_idx]),
                                   (i == int'(touch_idx))));
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign is_oldest[g] = (rank_q[g] == IW'(ENTRIES - 1));
  end

  always_comb begin
    logic [MAX_ENTRIES-1:0] wide;
    wide = '0;
    wide[ENTRIES-1:0] = is_oldest;
    lru_idx = IW'(lowest_set(wide));
  end

  // R8: a touched entry is the most recent one afterwards
  a_r8_touched_is_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> rank_q[$past(touch_idx)] == '0);

  // R7: ranks stay a permutation, so exactly one entry is oldest
  a_r7_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);

endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
  parameter int ENTRIES = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [IW-1:0]      lru_idx,
  output logic [IW-1:0]      alloc_idx,
  output logic               all_valid
);
  import vb_pkg::*;

  assign all_valid = &vld;

  always_comb begin
    logic [MAX_ENTRIES-1:0] wide;
    wide = '0;
    wide[ENTRIES-1:0] = ~vld;
    alloc_idx = all_valid ? lru_idx : IW'(lowest_set(wide));
  end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [DATA_W-1:0] sw_data
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;

  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      lru_idx;
  logic [IW-1:0]      alloc_idx;
  logic               all_valid;
  logic [IW-1:0]      wr_idx;
  logic               swap_in;
  logic               insert;
  logic               free_slot;

  vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .vld(vld_q), .tags(tag_q), .addr(lk_addr),
    .match(match_vec), .any(any_match), .idx(hit_idx)
  );

  vb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(ev_valid),
    .touch_idx(wr_idx), .lru_idx(lru_idx)
  );

  vb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .vld(vld_q), .lru_idx(lru_idx),
    .alloc_idx(alloc_idx), .all_valid(all_valid)
  );

  assign lk_hit    = lk_valid && any_match;
  assign lk_miss   = lk_valid && !any_match;
  assign sw_data   = lk_hit ? data_q[hit_idx] : '0;

  // named events for the checks below
  assign swap_in   = lk_hit && ev_valid;
  assign insert    = ev_valid && !lk_hit;
  assign free_slot = lk_hit && !ev_valid;
  assign wr_idx    = lk_hit ? hit_idx : alloc_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (ev_valid) begin
      vld_q[wr_idx] <= 1'b1;
    end else if (free_slot) begin
      vld_q[hit_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_valid) begin
      tag_q[wr_idx]  <= ev_addr;
      data_q[wr_idx] <= ev_data;
    end
  end

  // R1: reset leaves every slot empty
  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> vld_q == '0);

  // R2: a hit needs a lookup in the same cycle
  a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid && !lk_miss);

  // R4: the displaced block lands in the slot the hit came from
  a_r4_swap_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
    swap_in |=> vld_q[$past(hit_idx)] && tag_q[$past(hit_idx)] == $past(ev_addr));

  // R5: a hit with nothing to swap in frees its slot
  a_r5_free_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    free_slot |=> !vld_q[$past(hit_idx)]);

  // R6: an insertion never overwrites a valid slot while one is empty
  a_r6_fill_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    insert && !all_valid |-> !vld_q[alloc_idx]);

endmodule

// File: tb/test_victim_buffer.sv
`timescale 1ns/1ps
module test_victim_buffer;
  localparam int N  = 4;
  localparam int AW = 27;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          ev_valid = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic          lk_hit, lk_miss;
  logic [DW-1:0] sw_data;

  int nchk = 0;
  int nerr = 0;

  // reference model: last-write timestamps
  bit            m_v [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  int            m_t [N];
  int            stamp;

  always #2 clk = ~clk;

  victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) i_victim_buffer (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .sw_data(sw_data)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int pick_slot();
    int best;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (m_t[i] < m_t[best]) best = i;
    return best;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; ev_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_t[i] = 0; end
    stamp = 1;
  endtask

  task automatic op(string tag, bit lv, logic [AW-1:0] la, bit ev,
                    logic [AW-1:0] ea, logic [DW-1:0] ed, output bit got_hit);
    int k;
    bit eh;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; ev_valid = ev; ev_addr = ea; ev_data = ed;
    #1;
    k  = find(la);
    eh = lv && (k >= 0);
    chk(tag, "lk_hit", 64'(lk_hit), 64'(eh));
    chk(tag, "lk_miss", 64'(lk_miss), 64'(lv && !eh));
    if (eh) chk(tag, "sw_data", 64'(sw_data), 64'(m_d[k]));
    got_hit = lk_hit;
    @(posedge clk);
    if (ev) begin
      int s;
      s = eh ? k : pick_slot();
      m_v[s] = 1'b1; m_a[s] = ea; m_d[s] = ed; m_t[s] = stamp; stamp++;
    end else if (eh) begin
      m_v[k] = 1'b0;
    end
    #1;
    lk_valid = 1'b0; ev_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pay(logic [AW-1:0] a);
    return DW'(a) ^ 32'h5A5A_0000;
  endfunction

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    bit h;
    int fetches;
    bit pv;
    logic [AW-1:0] pa;
    void'($urandom(32'h0BAD_C0DE));

    // R1 / R2: empty after reset, idle produces nothing
    do_reset();
    op("R1", 1, 27'h10, 0, '0, '0, h);
    chk("R1", "first lookup", 64'(h), 64'd0);
    op("R2", 0, 27'h10, 0, '0, '0, h);

    // R6: fill every slot, all retained; R3 data; R4 swap; R5 free
    for (int i = 1; i <= N; i++) op("R6", 0, '0, 1, AW'(i), pay(AW'(i)), h);
    op("R6", 1, 27'h1, 1, 27'h9, pay(27'h9), h);
    chk("R6", "filled block kept", 64'(h), 64'd1);
    op("R4", 1, 27'h9, 0, '0, '0, h);
    chk("R4", "swapped block present", 64'(h), 64'd1);
    op("R5", 1, 27'h9, 0, '0, '0, h);
    chk("R5", "freed slot misses", 64'(h), 64'd0);
    op("R3", 1, 27'h4, 1, 27'hA, pay(27'hA), h);
    chk("R4", "other entries kept", 64'(h), 64'd1);

    // R7 / R8: replacement order
    do_reset();
    for (int i = 1; i <= N; i++) op("R7", 0, '0, 1, AW'(i), pay(AW'(i)), h);
    op("R7", 0, '0, 1, 27'h5, pay(27'h5), h);
    op("R7", 1, 27'h1, 0, '0, '0, h);
    chk("R7", "oldest replaced", 64'(h), 64'd0);
    op("R8", 1, 27'h2, 1, 27'h6, pay(27'h6), h);
    op("R8", 0, '0, 1, 27'h7, pay(27'h7), h);
    op("R8", 1, 27'h3, 0, '0, '0, h);
    chk("R8", "next oldest replaced", 64'(h), 64'd0);
    op("R8", 1, 27'h6, 0, '0, '0, h);
    chk("R8", "swapped block survived", 64'(h), 64'd1);

    // R9: alternating conflict trace through a one-line primary
    do_reset();
    fetches = 0; pv = 1'b0; pa = '0;
    for (int i = 0; i < 10; i++) begin
      logic [AW-1:0] a;
      a = (i % 2 == 0) ? 27'h40 : 27'h80;
      op("R9", 1, a, pv, pa, pay(pa), h);
      if (!h) fetches++;
      if (i >= 2) chk("R9", "served by swap", 64'(h), 64'd1);
      pv = 1'b1; pa = a;
    end
    chk("R9", "memory fetches", 64'(fetches), 64'd2);

    // R2 / R3: random traffic against the model
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] la, ea;
      bit lv, ev;
      lv = ($urandom % 4) != 0;
      ev = ($urandom % 3) != 0;
      la = AW'(27'h100 + ($urandom % 12));
      ea = la;
      while (ea == la || find(ea) >= 0) ea = AW'(27'h100 + ($urandom % 12));
      op("R3", lv, la, ev, ea, DW'($urandom), h);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule